// File: doc/BRIEF.md
# Serial Audio-Link Halt and Wake Controller

This block is the power-management controller of a modem codec that sits on a serial audio link. The link carries a bit clock, a frame sync, a link reset and a serial data line back to the controller. Software writes a small power register. One bit of that register halts the link. On a primary codec the halt stops the bit clock the codec drives and holds it low. On primary and secondary codecs alike, the halt forces the return data line low. A secondary codec receives its bit clock from outside, so the halt leaves that clock alone.

While the link is halted, the block watches for three ways out:
- **Cold reset:** a rising edge on the link reset.
- **Warm reset:** the frame sync held high for a set number of local clock cycles with no bit-clock edges seen.
- **Wake:** a ring event, which is honoured only while the GPIO power-down bit is clear.

A cold or warm resume clears the halt bit, and the bit clock restarts on the next local cycle. The rest of the power register is kept. A cold resume is treated exactly like a warm one: the wake status and caller-ID status flags live in always-powered logic and survive both. A wake event does not restart the bit clock. It releases only the data line, which is driven high to signal the host. Each resume cause is reported by a one-cycle pulse.

Top module: `link_pm_ctrl`

## Requirements
- R1: After `rst_n`, `pwr_state` is 0. A write stores `pwr_wr_data` into `pwr_state`. The bit positions are: bit 0 GPIO power-down, bit 1 reference power-down, bit 2 ADC power-down, bit 3 DAC power-down, bit 4 link halt.
- R2: On a primary codec (`is_primary`=1) with bit 4 set, `bclk_out` goes low within one cycle and stops toggling. With bit 4 clear and `link_rst_n` high, it toggles every `BCLK_HALF` cycles.
- R3: While bit 4 is set and no wake has been signalled, `sdi_out` is 0 whatever `sdi_core` is. With bit 4 clear, `sdi_out` follows `sdi_core`.
- R4: On a secondary codec `bclk_out` stays 0 at all times. The warm-reset detector watches `bclk_in` edges instead, so a sync held high while `bclk_in` toggles does not resume.
- R5: While halted, `sync_in` held high for `WARM_CYC` local cycles with no bit-clock edge gives one `res_warm` pulse. Bit 4 is then cleared, bits 3..0 are kept, and the bit clock restarts.
- R6: While halted, a rising edge on `link_rst_n` gives one `res_cold` pulse and clears bit 4 as a warm reset does. `wake_sts` and `cid_sts` keep their values. A rising edge while not halted gives no pulse.
- R7: While halted with bit 0 clear, a rising edge on `ring_in` gives one `res_wake` pulse and drives `sdi_out` high. Bit 4 stays set and the bit clock stays stopped. Further rings in the same halt give no further pulse.
- R8: With bit 0 set, a ring has no effect: no pulse, `sdi_out` stays 0 and `wake_sts` stays 0.
- R9: A wake sets `wake_sts`. It sets `cid_sts` only if bit 1 is also clear.
- R10: Any power-register write clears `wake_sts` and `cid_sts`.
- R11: A sync high time shorter than `WARM_CYC` cycles does not resume the link.
- R12: While `link_rst_n` is low, a primary codec's bit clock is stopped.
- R13: At most one of `res_cold`, `res_warm` and `res_wake` is high in any cycle. Cold takes priority over warm, and either takes priority over wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local clock |
| rst_n | input | 1 | Always-powered domain reset, active low |
| pwr_wr_en | input | 1 | Power register write strobe |
| pwr_wr_data | input | 5 | Power register write value |
| pwr_state | output | 5 | Current power register |
| is_primary | input | 1 | Strap: 1 primary, 0 secondary |
| bclk_in | input | 1 | Bit clock seen on the link (secondary) |
| bclk_out | output | 1 | Bit clock driven by a primary codec |
| sync_in | input | 1 | Frame sync from the controller |
| link_rst_n | input | 1 | Link reset, active low |
| sdi_core | input | 1 | Serial data from the codec core |
| sdi_out | output | 1 | Serial data line to the controller |
| ring_in | input | 1 | Ring / wake event input |
| res_cold | output | 1 | Pulse: resumed by link reset edge |
| res_warm | output | 1 | Pulse: resumed by warm reset |
| res_wake | output | 1 | Pulse: wake signalled on data line |
| wake_sts | output | 1 | Sticky wake status |
| cid_sts | output | 1 | Sticky caller-ID capture status |

## Verification
The bench measures the warm-reset time. A detector that counts off by a large margin fires outside the expected window, and one that never needed the full count would resume on the short sync pulse. On a secondary codec the bench holds sync high while it toggles `bclk_in`; a detector that ignored the external clock would wrongly resume there. After a wake, the bench drops and raises the link reset and then reads the two status flags. A design that treated the cold edge as a full reset would clear them. The bench also checks that a ring leaves the bit clock stopped and that it is ignored while the GPIO power-down bit is set.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int PWR_W  = 5;
  localparam int B_GPIO = 0;
  localparam int B_VREF = 1;
  localparam int B_ADC  = 2;
  localparam int B_DAC  = 3;
  localparam int B_HALT = 4;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_COLD = 2'd1,
    CAUSE_WARM = 2'd2,
    CAUSE_WAKE = 2'd3
  } cause_e;

  // Priority: cold over warm over wake (R13)
  function automatic cause_e pick_cause(input logic cold, input logic warm, input logic wake);
    if (cold)      return CAUSE_COLD;
    else if (warm) return CAUSE_WARM;
    else if (wake) return CAUSE_WAKE;
    else           return CAUSE_NONE;
  endfunction

  function automatic logic wake_allowed(input logic [PWR_W-1:0] p);
    return !p[B_GPIO];
  endfunction

  function automatic logic cid_allowed(input logic [PWR_W-1:0] p);
    return !p[B_GPIO] && !p[B_VREF];
  endfunction
endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q,
  output logic [N-1:0] q_prev
);
  localparam int DEPTH = STAGES + 1;
  logic [N-1:0] st [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < DEPTH; i++) st[i] <= st[i-1];
    end
  end

  assign q      = st[STAGES-1];
  assign q_prev = st[STAGES];
endmodule

// File: rtl/lpm_pwr_reg.sv
module lpm_pwr_reg
  import lpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PWR_W-1:0] wr_data,
  input  logic             halt_clr,
  output logic [PWR_W-1:0] q
);
  logic [PWR_W-1:0] nxt;

  always_comb begin
    nxt = wr_en ? wr_data : q;
    if (halt_clr) nxt[B_HALT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/lpm_bclk_gen.sv
module lpm_bclk_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic bclk
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      bclk <= ~bclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lpm_warm_det.sv
module lpm_warm_det #(
  parameter int WARM_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic sync_hi,
  input  logic clk_edge,
  output logic fire
);
  localparam int CW = $clog2(WARM_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WARM_CYC - 1);
  logic [CW-1:0] cnt;
  logic          quiet;

  assign quiet = armed && sync_hi && !clk_edge;
  assign fire  = quiet && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!quiet || fire) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lpm_wake_trk.sv
module lpm_wake_trk
  import lpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halted,
  input  logic             ring_rise,
  input  logic             resume,
  input  logic [PWR_W-1:0] pwr,
  input  logic             clr,
  output logic             wake_evt,
  output logic             wake_drive,
  output logic             wake_sts,
  output logic             cid_sts
);
  assign wake_evt = halted && ring_rise && wake_allowed(pwr) && !wake_drive && !resume;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wake_drive <= 1'b0;
    else if (resume || !halted) wake_drive <= 1'b0;
    else if (wake_evt)          wake_drive <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_sts <= 1'b0;
      cid_sts  <= 1'b0;
    end else if (clr) begin
      wake_sts <= 1'b0;
      cid_sts  <= 1'b0;
    end else if (wake_evt) begin
      wake_sts <= 1'b1;
      if (cid_allowed(pwr)) cid_sts <= 1'b1;
    end
  end
endmodule

// File: rtl/link_pm_ctrl.sv
module link_pm_ctrl
  import lpm_pkg::*;
#(
  parameter int BCLK_HALF   = 2,
  parameter int WARM_CYC    = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_wr_en,
  input  logic [PWR_W-1:0] pwr_wr_data,
  output logic [PWR_W-1:0] pwr_state,
  input  logic             is_primary,
  input  logic             bclk_in,
  output logic             bclk_out,
  input  logic             sync_in,
  input  logic             link_rst_n,
  input  logic             sdi_core,
  output logic             sdi_out,
  input  logic             ring_in,
  output logic             res_cold,
  output logic             res_warm,
  output logic             res_wake,
  output logic             wake_sts,
  output logic             cid_sts
);
  localparam int NSYNC = 4;
  localparam int I_RING = 0, I_LRST = 1, I_SYNC = 2, I_OBS = 3;

  logic [NSYNC-1:0] raw, s, sp;
  logic obs_raw, halted, clk_edge, cold_rise, warm_fire, resume;
  logic wake_evt, wake_drive, run;
  cause_e cause;

  assign obs_raw = is_primary ? bclk_out : bclk_in;
  assign raw[I_RING] = ring_in;
  assign raw[I_LRST] = link_rst_n;
  assign raw[I_SYNC] = sync_in;
  assign raw[I_OBS]  = obs_raw;

  lpm_sync #(.N(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(s), .q_prev(sp)
  );

  assign halted    = pwr_state[B_HALT];
  assign clk_edge  = s[I_OBS] ^ sp[I_OBS];
  assign cold_rise = s[I_LRST] && !sp[I_LRST];

  lpm_warm_det #(.WARM_CYC(WARM_CYC)) u_warm (
    .clk(clk), .rst_n(rst_n), .armed(halted), .sync_hi(s[I_SYNC]),
    .clk_edge(clk_edge), .fire(warm_fire)
  );

  assign resume = (halted && cold_rise) || warm_fire;

  lpm_pwr_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(pwr_wr_en), .wr_data(pwr_wr_data),
    .halt_clr(resume), .q(pwr_state)
  );

  lpm_wake_trk u_wake (
    .clk(clk), .rst_n(rst_n), .halted(halted),
    .ring_rise(s[I_RING] && !sp[I_RING]), .resume(resume), .pwr(pwr_state),
    .clr(pwr_wr_en), .wake_evt(wake_evt), .wake_drive(wake_drive),
    .wake_sts(wake_sts), .cid_sts(cid_sts)
  );

  assign run = is_primary && !halted && s[I_LRST];

  lpm_bclk_gen #(.HALF(BCLK_HALF)) u_bclk (
    .clk(clk), .rst_n(rst_n), .run(run), .bclk(bclk_out)
  );

  assign sdi_out = halted ? wake_drive : sdi_core;

  assign cause    = pick_cause(halted && cold_rise, warm_fire, wake_evt);
  assign res_cold = (cause == CAUSE_COLD);
  assign res_warm = (cause == CAUSE_WARM);
  assign res_wake = (cause == CAUSE_WAKE);
endmodule

// File: rtl/lpm_checker.sv
module lpm_checker
  import lpm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_wr_en,
  input logic [PWR_W-1:0] pwr_state,
  input logic             is_primary,
  input logic             bclk_out,
  input logic             sdi_out,
  input logic             res_cold,
  input logic             res_warm,
  input logic             res_wake,
  input logic             wake_sts,
  input logic             cid_sts,
  input logic             wake_drive
);
  p_bclk_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_primary && pwr_state[B_HALT] && $past(pwr_state[B_HALT])) |-> !bclk_out);

  p_sdi_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state[B_HALT] && !wake_drive) |-> !sdi_out);

  p_sec_bclk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_primary && $past(!is_primary)) |-> !bclk_out);

  p_warm_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_warm |=> !pwr_state[B_HALT]);

  p_cold_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_cold && !pwr_wr_en) |=> ($stable(wake_sts) && $stable(cid_sts) && !pwr_state[B_HALT]));

  p_wake_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_wake && !pwr_wr_en) |=> pwr_state[B_HALT]);

  p_ring_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_wake |-> !pwr_state[B_GPIO]);

  p_cid_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cid_sts) |-> !$past(pwr_state[B_VREF]));

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_wr_en |=> (!wake_sts && !cid_sts));

  p_one_cause_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_cold, res_warm, res_wake}));
endmodule

bind link_pm_ctrl lpm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_wr_en(pwr_wr_en), .pwr_state(pwr_state),
  .is_primary(is_primary), .bclk_out(bclk_out), .sdi_out(sdi_out),
  .res_cold(res_cold), .res_warm(res_warm), .res_wake(res_wake),
  .wake_sts(wake_sts), .cid_sts(cid_sts), .wake_drive(wake_drive)
);

// File: tb/sim_link_pm_ctrl.sv
`timescale 1ns/1ps
module sim_link_pm_ctrl;
  localparam int W = 100;

  logic clk = 0, rst_n = 0;
  logic pwr_wr_en = 0;
  logic [4:0] pwr_wr_data = 0;
  logic [4:0] pwr_state;
  logic is_primary = 1, bclk_in = 0, bclk_out, sync_in = 0, link_rst_n = 1;
  logic sdi_core = 0, sdi_out, ring_in = 0;
  logic res_cold, res_warm, res_wake, wake_sts, cid_sts;

  int checks = 0, errors = 0;
  int n_cold = 0, n_warm = 0, n_wake = 0;
  bit ext_clk_on = 0, done = 0;

  always #5 clk = ~clk;

  link_pm_ctrl #(.BCLK_HALF(2), .WARM_CYC(W)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_wr_en(pwr_wr_en), .pwr_wr_data(pwr_wr_data),
    .pwr_state(pwr_state), .is_primary(is_primary), .bclk_in(bclk_in),
    .bclk_out(bclk_out), .sync_in(sync_in), .link_rst_n(link_rst_n),
    .sdi_core(sdi_core), .sdi_out(sdi_out), .ring_in(ring_in),
    .res_cold(res_cold), .res_warm(res_warm), .res_wake(res_wake),
    .wake_sts(wake_sts), .cid_sts(cid_sts)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (res_cold) n_cold++;
      if (res_warm) n_warm++;
      if (res_wake) n_wake++;
    end
  end

  always @(negedge clk) if (ext_clk_on) bclk_in <= ~bclk_in;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_pwr(input logic [4:0] v);
    @(negedge clk);
    pwr_wr_en = 1; pwr_wr_data = v;
    @(negedge clk);
    pwr_wr_en = 0;
  endtask

  task automatic count_tog(input int n, output int t);
    logic p;
    t = 0;
    p = bclk_out;
    repeat (n) begin
      @(negedge clk);
      if (bclk_out != p) t++;
      p = bclk_out;
    end
  endtask

  task automatic clr_counts();
    n_cold = 0; n_warm = 0; n_wake = 0;
  endtask

  task automatic ring_once();
    @(negedge clk); ring_in = 1;
    wait_cyc(5);
    ring_in = 0;
    wait_cyc(6);
  endtask

  typedef struct packed {
    logic [4:0] data;
    logic       prim;
    logic       exp_run;
    logic       exp_follow;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{5'h00, 1'b1, 1'b1, 1'b1},
    '{5'h0C, 1'b1, 1'b1, 1'b1},
    '{5'h1C, 1'b1, 1'b0, 1'b0},
    '{5'h00, 1'b0, 1'b0, 1'b1},
    '{5'h1C, 1'b0, 1'b0, 1'b0},
    '{5'h13, 1'b1, 1'b0, 1'b0}
  };

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    int t, lat;
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(2);
    // R1 reset state
    chk(pwr_state == 5'h00, "R1 reset pwr_state", pwr_state, 0);
    chk(!wake_sts && !cid_sts, "R1 reset status", {wake_sts, cid_sts}, 0);

    // table walk: R1, R2, R3, R4
    for (int i = 0; i < NV; i++) begin
      is_primary = VEC[i].prim;
      write_pwr(VEC[i].data);
      wait_cyc(6);
      chk(pwr_state == VEC[i].data, "R1 stored value", pwr_state, VEC[i].data);
      count_tog(20, t);
      chk((t > 0) == VEC[i].exp_run, "R2/R4 bit clock activity", t, VEC[i].exp_run);
      sdi_core = 1;
      #1;
      chk(sdi_out == VEC[i].exp_follow, "R3 data line", sdi_out, VEC[i].exp_follow);
      sdi_core = 0;
      #1;
      chk(sdi_out == 0, "R3 data line low", sdi_out, 0);
    end

    // R5 warm reset on primary, with latency window
    is_primary = 1;
    write_pwr(5'h1C);
    wait_cyc(10);
    clr_counts();
    @(negedge clk); sync_in = 1;
    lat = -1;
    for (int i = 0; i < 3 * W; i++) begin
      @(negedge clk);
      if (res_warm && lat < 0) lat = i;
    end
    sync_in = 0;
    chk(lat >= W - 2 && lat <= W + 4, "R5 warm latency", lat, W);
    chk(n_warm == 1, "R5 single warm pulse", n_warm, 1);
    chk(pwr_state == 5'h0C, "R5 halt cleared others kept", pwr_state, 5'h0C);
    count_tog(20, t);
    chk(t > 0, "R5 bit clock restarted", t, 1);

    // R11 short sync does not resume
    write_pwr(5'h1C);
    wait_cyc(10);
    clr_counts();
    @(negedge clk); sync_in = 1;
    wait_cyc(W / 2);
    sync_in = 0;
    wait_cyc(10);
    chk(n_warm == 0, "R11 no warm on short sync", n_warm, 0);
    chk(pwr_state == 5'h1C, "R11 still halted", pwr_state, 5'h1C);

    // R4 secondary: toggling external clock blocks warm reset
    is_primary = 0;
    ext_clk_on = 1;
    wait_cyc(10);
    clr_counts();
    sync_in = 1;
    wait_cyc(W + 50);
    chk(n_warm == 0, "R4 warm blocked by bclk_in edges", n_warm, 0);
    chk(bclk_out == 0, "R4 secondary bclk_out low", bclk_out, 0);
    ext_clk_on = 0;
    wait_cyc(W + 20);
    sync_in = 0;
    chk(n_warm == 1, "R4 secondary warm once clock stops", n_warm, 1);
    chk(pwr_state == 5'h0C, "R4 secondary halt cleared", pwr_state, 5'h0C);
    bclk_in = 0;

    // R7 / R9 wake on primary with both gates clear
    is_primary = 1;
    write_pwr(5'h1C);
    wait_cyc(10);
    clr_counts();
    ring_once();
    chk(n_wake == 1, "R7 wake pulse", n_wake, 1);
    chk(sdi_out == 1, "R7 data line high on wake", sdi_out, 1);
    chk(pwr_state == 5'h1C, "R7 halt kept", pwr_state, 5'h1C);
    count_tog(20, t);
    chk(t == 0, "R7 bit clock stays stopped", t, 0);
    chk(wake_sts == 1, "R9 wake_sts set", wake_sts, 1);
    chk(cid_sts == 1, "R9 cid_sts set", cid_sts, 1);
    ring_once();
    chk(n_wake == 1, "R7 no second wake pulse", n_wake, 1);

    // R6 cold edge while halted keeps status
    clr_counts();
    @(negedge clk); link_rst_n = 0;
    wait_cyc(10);
    link_rst_n = 1;
    wait_cyc(10);
    chk(n_cold == 1, "R6 cold pulse", n_cold, 1);
    chk(pwr_state == 5'h0C, "R6 halt cleared", pwr_state, 5'h0C);
    chk(wake_sts == 1 && cid_sts == 1, "R6 status kept", {wake_sts, cid_sts}, 3);
    count_tog(20, t);
    chk(t > 0, "R6 bit clock restarted", t, 1);
    chk(n_warm == 0 && n_wake == 0, "R13 only cold reported", n_warm + n_wake, 0);

    // R12 link reset low stops clock; R6 edge while running gives no pulse
    clr_counts();
    @(negedge clk); link_rst_n = 0;
    wait_cyc(8);
    count_tog(20, t);
    chk(t == 0, "R12 clock stopped during link reset", t, 0);
    link_rst_n = 1;
    wait_cyc(10);
    chk(n_cold == 0, "R6 no pulse when not halted", n_cold, 0);

    // R10 write clears status
    write_pwr(5'h1C);
    wait_cyc(2);
    chk(!wake_sts && !cid_sts, "R10 status cleared by write", {wake_sts, cid_sts}, 0);

    // R8 ring ignored with GPIO power-down set
    write_pwr(5'h1D);
    wait_cyc(10);
    clr_counts();
    ring_once();
    chk(n_wake == 0, "R8 no wake pulse", n_wake, 0);
    chk(sdi_out == 0, "R8 data line low", sdi_out, 0);
    chk(wake_sts == 0, "R8 wake_sts clear", wake_sts, 0);

    // R9 reference power-down blocks caller-ID only
    write_pwr(5'h1E);
    wait_cyc(10);
    clr_counts();
    ring_once();
    chk(n_wake == 1, "R9 wake with vref off", n_wake, 1);
    chk(wake_sts == 1, "R9 wake_sts set", wake_sts, 1);
    chk(cid_sts == 0, "R9 cid_sts blocked", cid_sts, 0);

    done = 1;
    finish_run();
  end
endmodule